// File: doc/BRIEF.md
# Debug Register Front-End

This block is the register layer of a hardware debug unit. A debugger reaches it through a word-addressed request port. Each request carries an address, write data, a write flag and a valid strobe. Exactly one cycle later the block returns a response with read data and an error flag. The block decodes the address to one of these targets:

- a small array of 32-bit data words;
- a program-buffer array;
- a control register;
- a command status register;
- a read-only capability register;
- a command address. A write here is passed on as a one-cycle strobe to a separate command engine.

The block drives one halt-request line per hart and a shared reset-request line. The per-hart halted inputs feed a run/halt status that is computed live whenever the control register is read. The command engine uses a second, byte-addressed little-endian port to read and write the data words. This lets it move hart register values through the same storage the debugger sees.

Top module: `dmfe_top`

## Requirements
- R1: Every cycle with `reqValid` high is followed in the next cycle by `rspValid` high. A cycle without a request is followed by `rspValid` low. A write response carries read data 0.
- R2: Addresses 0x04..0x07 read and write data words 0..3. Addresses 0x20..0x27 read and write program-buffer words 0..7.
- R3: An address outside every mapped range answers with `rspErr` = 1 and data 0, and a write there changes no state. The mapped ranges are 0x04..0x07, 0x10..0x13 and 0x20..0x27.
- R4: A write to the control address 0x10 always loads the active bit (bit 0). It loads the reset request (bit 1), the hart selection (bits 9:4) and the selected hart's halt request (bit 2) only when bit 0 of that same write is 1.
- R5: Bits 11:10 of a control read give the selected hart's status: 2'b01 halted, 2'b00 running, 2'b11 not present (the selection is at or beyond the hart count).
- R6: A control read returns the halt request currently driven to the selected hart in bit 2 (0 if that hart is absent). It also returns the active bit in bit 0, the reset request in bit 1, the selection in bits 9:4, and these constants: 1 in bit 12, 0 in bit 13, 0 in bits 15:14 and version 1 in bits 19:16.
- R7: A read of the status address 0x11 returns the data-word count in bits 3:0, the command error in bits 10:8, the engine busy input in bit 12 and eight writable auto-execute bits in bits 23:16.
- R8: An engine error pulse loads its code into the command error only while that error is 0. A status write clears the error only when bits 10:8 of the written value are 0, and that clear wins over a pulse in the same cycle. Otherwise the error holds.
- R9: A write to the command address 0x12 raises `cmdValid` for one cycle, aligned with its response, with the written word on `cmdWord`. Reads of 0x12 return 0 without error and raise no strobe.
- R10: A read of the capability address 0x13 returns the program-buffer size in bits 20:16 and 0 in all other bits. Writes there are accepted and ignored.
- R11: The hart port addresses data words by byte. Word = address bits 4:2 and byte offset = bits 1:0. Writes shift the byte enables and data up by the offset, with lanes past byte 3 dropped. Reads return the word shifted down by the offset, one cycle later. Words beyond the last data word are ignored on write and read as 0. A hart-port write wins byte by byte over a debugger write to the same word in the same cycle.
- R12: After reset the halt requests, reset request, active bit, hart selection, command error, auto-execute bits and all data and program-buffer words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Debugger request strobe |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | 7 | Word address |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspRdata | output | 32 | Read data |
| rspErr | output | 1 | Address not mapped |
| hartHalted | input | 4 | Per-hart halted flags |
| haltReqOut | output | 4 | Per-hart halt requests |
| resetReqOut | output | 1 | Reset request field |
| cmdValid | output | 1 | Command strobe to the engine |
| cmdWord | output | 32 | Command word |
| cmdBusy | input | 1 | Engine busy |
| cmdErrValid | input | 1 | Engine error pulse |
| cmdErrCode | input | 3 | Engine error code |
| hsValid | input | 1 | Hart-port access strobe |
| hsWrite | input | 1 | Hart-port write |
| hsAddr | input | 5 | Hart-port byte address |
| hsByteEn | input | 4 | Hart-port byte enables |
| hsWdata | input | 32 | Hart-port write data |
| hsRdata | output | 32 | Hart-port read data |

## Verification
The assertions assume the following about the inputs:
- `hartHalted` and `cmdBusy` stay steady around the clock edge that samples a request.
- An engine error arrives as a single-cycle `cmdErrValid` pulse.
- The default address ranges do not overlap.

The bench meets these assumptions by changing every input only on the falling edge. It gives each error pulse exactly one cycle. It draws hart states, busy levels, addresses and data from a fixed-seed random stream. Random addresses are weighted toward mapped ranges, with a share of arbitrary ones that fall into unmapped gaps.

// File: rtl/dmfe_pkg.sv
package dmfe_pkg;
  localparam int IDX_W = 8;
  localparam int SEL_W = 6;

  // control word layout
  localparam int CT_ACTIVE      = 0;
  localparam int CT_RESET       = 1;
  localparam int CT_HALTREQ     = 2;
  localparam int CT_SEL_LO      = 4;
  localparam int CT_STAT_LO     = 10;
  localparam int CT_AUTHOK      = 12;
  localparam int CT_AUTHBUSY    = 13;
  localparam int CT_AUTHTYPE_LO = 14;
  localparam int CT_VER_LO      = 16;

  // status word layout
  localparam int ST_COUNT_LO = 0;
  localparam int ST_ERR_LO   = 8;
  localparam int ST_BUSY     = 12;
  localparam int ST_AUTO_LO  = 16;

  // capability word layout
  localparam int AC_PROG_LO = 16;

  typedef enum logic [1:0] {
    HART_RUNNING = 2'b00,
    HART_HALTED  = 2'b01,
    HART_ABSENT  = 2'b11
  } hartStat_e;

  // strobes from control to the word storage
  typedef struct packed {
    logic             dataWe;
    logic             progWe;
    logic [IDX_W-1:0] idx;
    logic [31:0]      wdata;
  } arrStrobe_t;
endpackage

// File: rtl/dmfe_data.sv
module dmfe_data
  import dmfe_pkg::*;
#(
  parameter int DATA_COUNT = 4,
  parameter int PROG_SIZE  = 8,
  parameter int HS_AW      = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  arrStrobe_t       strobeIn,
  input  logic             hsValid,
  input  logic             hsWrite,
  input  logic [HS_AW-1:0] hsAddr,
  input  logic [3:0]       hsByteEn,
  input  logic [31:0]      hsWdata,
  output logic [31:0]      dataRd,
  output logic [31:0]      progRd,
  output logic [31:0]      hsRdata
);
  localparam int LANES = 4;

  logic [31:0] dataMem  [DATA_COUNT];
  logic [31:0] dataNext [DATA_COUNT];
  logic [31:0] progMem  [PROG_SIZE];
  logic [31:0] progNext [PROG_SIZE];

  int          armIdx;
  int          hsWord;
  logic [1:0]  hsOff;
  logic [3:0]  laneEn;
  logic [31:0] laneData;
  logic [31:0] hsRdSel;
  logic        hsInRange;

  always_comb begin
    armIdx    = int'(strobeIn.idx);
    hsWord    = int'(hsAddr[HS_AW-1:2]);
    hsOff     = hsAddr[1:0];
    laneEn    = 4'(hsByteEn << hsOff);
    laneData  = hsWdata << {hsOff, 3'b000};
    hsInRange = hsWord < DATA_COUNT;
  end

  // next state of the data words: debugger word write, then hart byte lanes
  always_comb begin
    for (int w = 0; w < DATA_COUNT; w++) begin
      dataNext[w] = dataMem[w];
      if (strobeIn.dataWe && armIdx == w) dataNext[w] = strobeIn.wdata;
      if (hsValid && hsWrite && hsWord == w) begin
        for (int b = 0; b < LANES; b++) begin
          if (laneEn[b]) dataNext[w][8*b +: 8] = laneData[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    for (int w = 0; w < PROG_SIZE; w++) begin
      progNext[w] = progMem[w];
      if (strobeIn.progWe && armIdx == w) progNext[w] = strobeIn.wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DATA_COUNT; w++) dataMem[w] <= '0;
      for (int w = 0; w < PROG_SIZE; w++) progMem[w] <= '0;
    end else begin
      dataMem <= dataNext;
      progMem <= progNext;
    end
  end

  // read selection for the debugger side
  always_comb begin
    dataRd = '0;
    progRd = '0;
    hsRdSel = '0;
    for (int w = 0; w < DATA_COUNT; w++) begin
      if (armIdx == w) dataRd = dataMem[w];
      if (hsWord == w) hsRdSel = dataMem[w] >> {hsOff, 3'b000};
    end
    for (int w = 0; w < PROG_SIZE; w++) begin
      if (armIdx == w) progRd = progMem[w];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hsRdata <= '0;
    else if (hsValid && !hsWrite) hsRdata <= hsRdSel;
  end

  // R11: hart write beyond the data words leaves word 0 untouched
  p_hs_oob_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && hsWrite && !hsInRange && !strobeIn.dataWe) |=> $stable(dataMem[0]));

  // R2: a lone debugger write to word 0 is stored as written
  p_dmi_word_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobeIn.dataWe && armIdx == 0 && !(hsValid && hsWrite))
      |=> dataMem[0] == $past(strobeIn.wdata));

  // R11: out-of-range hart read returns zero
  p_hs_oob_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (hsValid && !hsWrite && !hsInRange) |=> hsRdata == 32'd0);
endmodule

// File: rtl/dmfe_ctrl.sv
module dmfe_ctrl
  import dmfe_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int DATA_COUNT = 4,
  parameter int PROG_SIZE  = 8,
  parameter int ADDR_W     = 7,
  parameter int DATA_BASE  = 'h04,
  parameter int CTRL_ADDR  = 'h10,
  parameter int STAT_ADDR  = 'h11,
  parameter int CMD_ADDR   = 'h12,
  parameter int ACC_ADDR   = 'h13,
  parameter int PROG_BASE  = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  input  logic [NHARTS-1:0] hartHalted,
  output logic [NHARTS-1:0] haltReqOut,
  output logic              resetReqOut,
  output logic              cmdValid,
  output logic [31:0]       cmdWord,
  input  logic              cmdBusy,
  input  logic              cmdErrValid,
  input  logic [2:0]        cmdErrCode,
  output arrStrobe_t        strobeOut,
  input  logic [31:0]       dataRd,
  input  logic [31:0]       progRd
);
  localparam int SEL_SPAN = 1 << SEL_W;

  logic              active;
  logic              resetReq;
  logic [SEL_W-1:0]  hartSel;
  logic [NHARTS-1:0] haltReq;
  logic [2:0]        cmdErr;
  logic [7:0]        autoExec;

  int   addrInt;
  logic hitData, hitProg, hitCtrl, hitStat, hitCmd, hitAcc;
  logic wr, errClear, selPresent;
  logic [SEL_W-1:0]    newSel;
  logic [SEL_SPAN-1:0] haltedPad, haltReqPad;
  hartStat_e           curStat;
  logic [31:0] ctrlWord, statWord, accWord, rdNext;
  logic        errNext;

  // address decode
  always_comb begin
    addrInt = int'(reqAddr);
    hitData = (addrInt >= DATA_BASE) && (addrInt < DATA_BASE + DATA_COUNT);
    hitProg = (addrInt >= PROG_BASE) && (addrInt < PROG_BASE + PROG_SIZE);
    hitCtrl = addrInt == CTRL_ADDR;
    hitStat = addrInt == STAT_ADDR;
    hitCmd  = addrInt == CMD_ADDR;
    hitAcc  = addrInt == ACC_ADDR;
    errNext = !(hitData || hitProg || hitCtrl || hitStat || hitCmd || hitAcc);
    wr      = reqValid && reqWrite;
  end

  always_comb begin
    strobeOut.dataWe = wr && hitData;
    strobeOut.progWe = wr && hitProg;
    strobeOut.idx    = hitData ? IDX_W'(addrInt - DATA_BASE) : IDX_W'(addrInt - PROG_BASE);
    strobeOut.wdata  = reqWdata;
  end

  // live hart status
  always_comb begin
    newSel     = reqWdata[CT_SEL_LO +: SEL_W];
    selPresent = int'(hartSel) < NHARTS;
    haltedPad  = SEL_SPAN'(hartHalted);
    haltReqPad = SEL_SPAN'(haltReq);
    if (!selPresent)             curStat = HART_ABSENT;
    else if (haltedPad[hartSel]) curStat = HART_HALTED;
    else                         curStat = HART_RUNNING;
  end

  // read words
  always_comb begin
    ctrlWord = '0;
    ctrlWord[CT_ACTIVE]              = active;
    ctrlWord[CT_RESET]               = resetReq;
    ctrlWord[CT_HALTREQ]             = selPresent && haltReqPad[hartSel];
    ctrlWord[CT_SEL_LO +: SEL_W]     = hartSel;
    ctrlWord[CT_STAT_LO +: 2]        = curStat;
    ctrlWord[CT_AUTHOK]              = 1'b1;
    ctrlWord[CT_AUTHBUSY]            = 1'b0;
    ctrlWord[CT_AUTHTYPE_LO +: 2]    = 2'b00;
    ctrlWord[CT_VER_LO +: 4]         = 4'd1;

    statWord = '0;
    statWord[ST_COUNT_LO +: 4] = 4'(DATA_COUNT);
    statWord[ST_ERR_LO +: 3]   = cmdErr;
    statWord[ST_BUSY]          = cmdBusy;
    statWord[ST_AUTO_LO +: 8]  = autoExec;

    accWord = 32'(PROG_SIZE) << AC_PROG_LO;

    if (hitData)      rdNext = dataRd;
    else if (hitProg) rdNext = progRd;
    else if (hitCtrl) rdNext = ctrlWord;
    else if (hitStat) rdNext = statWord;
    else if (hitAcc)  rdNext = accWord;
    else              rdNext = '0;
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      resetReq <= 1'b0;
      hartSel  <= '0;
      haltReq  <= '0;
    end else if (wr && hitCtrl) begin
      active <= reqWdata[CT_ACTIVE];
      if (reqWdata[CT_ACTIVE]) begin
        resetReq <= reqWdata[CT_RESET];
        hartSel  <= newSel;
        for (int h = 0; h < NHARTS; h++) begin
          if (int'(newSel) == h) haltReq[h] <= reqWdata[CT_HALTREQ];
        end
      end
    end
  end

  // status register
  assign errClear = wr && hitStat && (reqWdata[ST_ERR_LO +: 3] == 3'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdErr   <= 3'd0;
      autoExec <= 8'd0;
    end else begin
      if (wr && hitStat) autoExec <= reqWdata[ST_AUTO_LO +: 8];
      if (errClear) cmdErr <= 3'd0;
      else if (cmdErrValid && cmdErr == 3'd0) cmdErr <= cmdErrCode;
    end
  end

  // response and command strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
      rspErr   <= 1'b0;
      cmdValid <= 1'b0;
      cmdWord  <= '0;
    end else begin
      rspValid <= reqValid;
      rspRdata <= (reqValid && !reqWrite && !errNext) ? rdNext : 32'd0;
      rspErr   <= reqValid && errNext;
      cmdValid <= wr && hitCmd;
      if (wr && hitCmd) cmdWord <= reqWdata;
    end
  end

  assign haltReqOut  = haltReq;
  assign resetReqOut = resetReq;

  // R1: response follows each request by one cycle
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R3: error responses carry no data
  p_err_no_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == 32'd0));

  // R4: inactive control write keeps the hart-facing fields
  p_inactive_keeps_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wr && hitCtrl && !reqWdata[CT_ACTIVE]) |=> ($stable(haltReqOut) && $stable(resetReqOut)));

  // R5: a selection beyond the hart count reads as absent
  p_absent_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && hitCtrl && int'(hartSel) >= NHARTS)
      |=> rspRdata[CT_STAT_LO +: 2] == 2'b11);

  // R8: a set error holds unless cleared by a status write
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr != 3'd0 && !errClear) |=> cmdErr == $past(cmdErr));

  // R9: command strobe rides on a clean response
  p_cmd_with_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (rspValid && !rspErr));
endmodule

// File: rtl/dmfe_top.sv
module dmfe_top
  import dmfe_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int DATA_COUNT = 4,
  parameter int PROG_SIZE  = 8,
  parameter int ADDR_W     = 7,
  parameter int HS_AW      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  input  logic [NHARTS-1:0] hartHalted,
  output logic [NHARTS-1:0] haltReqOut,
  output logic              resetReqOut,
  output logic              cmdValid,
  output logic [31:0]       cmdWord,
  input  logic              cmdBusy,
  input  logic              cmdErrValid,
  input  logic [2:0]        cmdErrCode,
  input  logic              hsValid,
  input  logic              hsWrite,
  input  logic [HS_AW-1:0]  hsAddr,
  input  logic [3:0]        hsByteEn,
  input  logic [31:0]       hsWdata,
  output logic [31:0]       hsRdata
);
  arrStrobe_t  arrStrobe;
  logic [31:0] dataRd;
  logic [31:0] progRd;

  dmfe_ctrl #(
    .NHARTS(NHARTS), .DATA_COUNT(DATA_COUNT), .PROG_SIZE(PROG_SIZE), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .hartHalted(hartHalted), .haltReqOut(haltReqOut), .resetReqOut(resetReqOut),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .cmdBusy(cmdBusy),
    .cmdErrValid(cmdErrValid), .cmdErrCode(cmdErrCode),
    .strobeOut(arrStrobe), .dataRd(dataRd), .progRd(progRd)
  );

  dmfe_data #(
    .DATA_COUNT(DATA_COUNT), .PROG_SIZE(PROG_SIZE), .HS_AW(HS_AW)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobeIn(arrStrobe),
    .hsValid(hsValid), .hsWrite(hsWrite), .hsAddr(hsAddr),
    .hsByteEn(hsByteEn), .hsWdata(hsWdata),
    .dataRd(dataRd), .progRd(progRd), .hsRdata(hsRdata)
  );
endmodule

// File: tb/tb_dmfe_top.sv
module tb_dmfe_top;
  localparam logic [6:0] A_CTRL = 7'h10, A_STAT = 7'h11, A_CMD = 7'h12, A_ACC = 7'h13;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [6:0]  reqAddr;
  logic [31:0] reqWdata;
  logic        rspValid, rspErr;
  logic [31:0] rspRdata;
  logic [3:0]  hartHalted, haltReqOut;
  logic        resetReqOut, cmdValid, cmdBusy, cmdErrValid;
  logic [31:0] cmdWord;
  logic [2:0]  cmdErrCode;
  logic        hsValid, hsWrite;
  logic [4:0]  hsAddr;
  logic [3:0]  hsByteEn;
  logic [31:0] hsWdata, hsRdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [31:0] mData [4];
  logic [31:0] mProg [8];
  logic        mActive, mReset;
  logic [5:0]  mSel;
  logic [3:0]  mHalt;
  logic [2:0]  mErr;
  logic [7:0]  mAuto;

  always #2 clk = ~clk;

  dmfe_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata), .rspErr(rspErr),
    .hartHalted(hartHalted), .haltReqOut(haltReqOut), .resetReqOut(resetReqOut),
    .cmdValid(cmdValid), .cmdWord(cmdWord), .cmdBusy(cmdBusy), .cmdErrValid(cmdErrValid),
    .cmdErrCode(cmdErrCode), .hsValid(hsValid), .hsWrite(hsWrite), .hsAddr(hsAddr),
    .hsByteEn(hsByteEn), .hsWdata(hsWdata), .hsRdata(hsRdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic logic [31:0] ctrlExp();
    logic [31:0] v = '0;
    v[0] = mActive;
    v[1] = mReset;
    v[9:4] = mSel;
    if (mSel < 6'd4) begin
      v[2] = mHalt[mSel[1:0]];
      v[11:10] = hartHalted[mSel[1:0]] ? 2'b01 : 2'b00;
    end else begin
      v[11:10] = 2'b11;
    end
    v[12] = 1'b1;
    v[19:16] = 4'd1;
    return v;
  endfunction

  function automatic logic [31:0] expRead(input logic [6:0] a, output logic e);
    int ai = int'(a);
    e = 1'b0;
    if (ai >= 4 && ai < 8) return mData[ai-4];
    if (ai >= 32 && ai < 40) return mProg[ai-32];
    if (a == A_CTRL) return ctrlExp();
    if (a == A_STAT) return {8'd0, mAuto, 3'd0, cmdBusy, 1'b0, mErr, 4'd0, 4'd4};
    if (a == A_CMD) return 32'd0;
    if (a == A_ACC) return 32'd8 << 16;
    e = 1'b1;
    return 32'd0;
  endfunction

  function automatic string tagOf(input logic [6:0] a);
    int ai = int'(a);
    if ((ai >= 4 && ai < 8) || (ai >= 32 && ai < 40)) return "R2 word array";
    if (a == A_CTRL) return "R6 control read";
    if (a == A_STAT) return "R7 status read";
    if (a == A_CMD)  return "R9 command read";
    if (a == A_ACC)  return "R10 capability read";
    return "R3 unmapped";
  endfunction

  task automatic doOp(input logic wr, input logic [6:0] a, input logic [31:0] w);
    logic [31:0] expD, rd, cw;
    logic eErr, er, cv, rv;
    int ai = int'(a);
    expD = expRead(a, eErr);
    if (wr) expD = 32'd0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = w;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    rd = rspRdata; er = rspErr; cv = cmdValid; cw = cmdWord; rv = rspValid;
    chk(rv === 1'b1, "R1 response valid", 32'(rv), 32'd1);
    chk(rd === expD, tagOf(a), rd, expD);
    chk(er === eErr, "R3 error flag", 32'(er), 32'(eErr));
    chk(cv === (wr && a == A_CMD), "R9 command strobe", 32'(cv), 32'(wr && a == A_CMD));
    if (cv) chk(cw === w, "R9 command word", cw, w);
    if (wr) begin
      if (ai >= 4 && ai < 8) mData[ai-4] = w;
      else if (ai >= 32 && ai < 40) mProg[ai-32] = w;
      else if (a == A_CTRL) begin
        mActive = w[0];
        if (w[0]) begin
          mReset = w[1];
          mSel = w[9:4];
          if (w[9:4] < 6'd4) mHalt[w[5:4]] = w[2];
        end
      end else if (a == A_STAT) begin
        mAuto = w[23:16];
        if (w[10:8] == 3'd0) mErr = 3'd0;
      end
      chk(haltReqOut === mHalt, "R4 halt request outputs", 32'(haltReqOut), 32'(mHalt));
      chk(resetReqOut === mReset, "R4 reset request output", 32'(resetReqOut), 32'(mReset));
    end
  endtask

  task automatic hsOp(input logic wr, input logic [4:0] a, input logic [3:0] be,
                      input logic [31:0] w, output logic [31:0] rd);
    @(negedge clk);
    hsValid = 1'b1; hsWrite = wr; hsAddr = a; hsByteEn = be; hsWdata = w;
    @(negedge clk);
    hsValid = 1'b0; hsWrite = 1'b0;
    rd = hsRdata;
  endtask

  task automatic engErr(input logic [2:0] code);
    @(negedge clk);
    cmdErrValid = 1'b1; cmdErrCode = code;
    @(negedge clk);
    cmdErrValid = 1'b0;
    if (mErr == 3'd0) mErr = code;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [31:0] rd, exp;
    void'($urandom(32'h5eed));
    rstN = 1'b0; reqValid = 0; reqWrite = 0; reqAddr = 0; reqWdata = 0;
    hartHalted = 0; cmdBusy = 0; cmdErrValid = 0; cmdErrCode = 0;
    hsValid = 0; hsWrite = 0; hsAddr = 0; hsByteEn = 0; hsWdata = 0;
    foreach (mData[i]) mData[i] = 0;
    foreach (mProg[i]) mProg[i] = 0;
    mActive = 0; mReset = 0; mSel = 0; mHalt = 0; mErr = 0; mAuto = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk(haltReqOut === 4'd0, "R12 halt requests after reset", 32'(haltReqOut), 0);
    chk(resetReqOut === 1'b0, "R12 reset request after reset", 32'(resetReqOut), 0);
    chk(rspValid === 1'b0, "R1 idle response", 32'(rspValid), 0);
    doOp(0, A_CTRL, 0);
    doOp(0, A_STAT, 0);
    for (int i = 0; i < 4; i++) doOp(0, 7'(4 + i), 0);
    for (int i = 0; i < 8; i++) doOp(0, 7'(32 + i), 0);
    @(negedge clk);
    chk(rspValid === 1'b0, "R1 no response without request", 32'(rspValid), 0);

    // R4 inactive write loads only the active bit
    doOp(1, A_CTRL, 32'h0000_0026);
    doOp(0, A_CTRL, 0);
    // R4 / R5 active write selects hart 2 and requests halt
    doOp(1, A_CTRL, 32'h0000_0027);
    hartHalted = 4'b0100;
    doOp(0, A_CTRL, 0);
    hartHalted = 4'b0000;
    doOp(0, A_CTRL, 0);
    // R5 absent hart
    doOp(1, A_CTRL, 32'h0000_0051);
    hartHalted = 4'b1111;
    doOp(0, A_CTRL, 0);
    // R4 inactive write does not move the selection or halt lines
    doOp(1, A_CTRL, 32'h0000_0014);
    doOp(0, A_CTRL, 0);
    doOp(1, A_CTRL, 32'h0000_0025);
    doOp(0, A_CTRL, 0);

    // R7 status fields
    cmdBusy = 1'b1;
    doOp(1, A_STAT, 32'h00A5_0000);
    doOp(0, A_STAT, 0);
    cmdBusy = 1'b0;

    // R8 error latch
    engErr(3'd3);
    doOp(0, A_STAT, 0);
    engErr(3'd5);
    doOp(0, A_STAT, 0);
    doOp(1, A_STAT, 32'h0000_0100);
    doOp(0, A_STAT, 0);
    doOp(1, A_STAT, 32'h0000_0000);
    doOp(0, A_STAT, 0);
    // R8 clear wins over a same-cycle pulse
    engErr(3'd2);
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = A_STAT; reqWdata = 32'h0; cmdErrValid = 1; cmdErrCode = 3'd6;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; cmdErrValid = 0;
    mErr = 0; mAuto = 0;
    doOp(0, A_STAT, 0);

    // R9 command forwarding
    doOp(1, A_CMD, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(cmdValid === 1'b0, "R9 strobe lasts one cycle", 32'(cmdValid), 0);
    doOp(0, A_CMD, 0);

    // R10 capability register
    doOp(1, A_ACC, 32'hFFFF_FFFF);
    doOp(0, A_ACC, 0);

    // R2 / R3 boundaries
    doOp(1, 7'h07, 32'h7777_0007);
    doOp(1, 7'h08, 32'h8888_0008);
    doOp(0, 7'h08, 0);
    doOp(1, 7'h27, 32'h2727_2727);
    doOp(1, 7'h28, 32'h2828_2828);
    doOp(0, 7'h28, 0);
    doOp(0, 7'h03, 0);
    doOp(1, 7'h7F, 32'h1234_5678);
    doOp(0, 7'h07, 0);
    doOp(0, 7'h27, 0);
    doOp(0, A_CTRL, 0);

    // R11 hart port
    doOp(1, 7'h05, 32'h1122_3344);
    hsOp(0, 5'd4, 4'hF, 0, rd);
    chk(rd === 32'h1122_3344, "R11 hart read word", rd, 32'h1122_3344);
    hsOp(0, 5'd6, 4'hF, 0, rd);
    chk(rd === 32'h0000_1122, "R11 hart read offset", rd, 32'h0000_1122);
    hsOp(1, 5'd9, 4'b0001, 32'h0000_00AB, rd);
    mData[2] = (mData[2] & 32'hFFFF_00FF) | 32'h0000_AB00;
    doOp(0, 7'h06, 0);
    hsOp(1, 5'd3, 4'b0011, 32'h0000_CDEF, rd);
    mData[0] = (mData[0] & 32'h00FF_FFFF) | 32'hEF00_0000;
    doOp(0, 7'h04, 0);
    hsOp(1, 5'd16, 4'hF, 32'hFFFF_FFFF, rd);
    for (int i = 0; i < 4; i++) doOp(0, 7'(4 + i), 0);
    hsOp(0, 5'd20, 4'hF, 0, rd);
    chk(rd === 32'd0, "R11 out-of-range hart read", rd, 0);
    // R11 collision: hart lanes win
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 7'h04; reqWdata = 32'hAAAA_AAAA;
    hsValid = 1; hsWrite = 1; hsAddr = 5'd0; hsByteEn = 4'b0011; hsWdata = 32'h0000_5555;
    @(negedge clk);
    reqValid = 0; reqWrite = 0; hsValid = 0; hsWrite = 0;
    mData[0] = 32'hAAAA_5555;
    doOp(0, 7'h04, 0);
    hsOp(0, 5'd0, 4'hF, 0, rd);
    chk(rd === 32'hAAAA_5555, "R11 collision hart read", rd, 32'hAAAA_5555);

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int pick = int'($urandom % 10);
      logic [6:0] a;
      logic [31:0] w = $urandom;
      logic wr = 1'($urandom);
      hartHalted = 4'($urandom);
      cmdBusy = 1'($urandom);
      case (pick)
        0, 1, 2: a = 7'(4 + ($urandom % 4));
        3, 4:    a = 7'(32 + ($urandom % 8));
        5: begin a = A_CTRL; w[9:4] = 6'($urandom % 8); end
        6: a = A_STAT;
        7: a = A_CMD;
        8: a = A_ACC;
        default: a = 7'($urandom);
      endcase
      doOp(wr, a, w);
    end

    done = 1;
    report();
  end
endmodule